// File: doc/BRIEF.md
# Circular SRAM Queue Controller

This block manages a single word-wide queue that lives as a ring buffer inside a shared SRAM region. One access port serves both directions: a push stores a word at the tail and a pop returns the word at the head. A 32-bit configuration word selects the ring size, the base of the ring within the SRAM, and two watermarks. The same word reads back the current head and tail pointers, so software can work out how many words are queued without any further status.

Status outputs report empty, nearly-empty, nearly-full and full. Popping an empty queue returns zero and raises a sticky underflow flag. Pushing into a full queue discards the word and raises a sticky overflow flag. Software clears either flag by writing the flag word back with that bit at zero. A behavioural word array stands in for the SRAM macro.

Top module: `sram_queue_ctrl`

## Requirements
- R1: After reset the configuration word reads 0x00000000, which means a 16-word ring at base 0 with both watermark codes 0. q_empty and q_nearly_empty are 1. q_nearly_full, q_full, q_underflow and q_overflow are 0, and pop_data is 0.
- R2: A configuration write sets the ring size from cfg_wdata[17:16], the base (in 16-word units) from [24:18], the nearly-empty code from [27:25] and the nearly-full code from [30:28]. The same write zeroes both pointers, so the queue starts empty. Bits [15:0] and [31] of the write are ignored, and on read they hold the pointers, an entry-size field fixed at 00 (one word), and 0.
- R3: Popped words come out in the order they were pushed, across wrap-around of the ring, one cycle after the pop edge on pop_data.
- R4: The tail pointer reads in cfg_rdata[6:0] and the head pointer in [13:7]. Each accepted push or pop advances its pointer by one modulo 128. For rings smaller than 128 words, (tail − head) mod 128 equals the number of queued words.
- R5: A pop on an empty queue loads 0x00000000 into pop_data, leaves both pointers unchanged and sets q_underflow.
- R6: A push on a full queue is discarded: the tail pointer and the stored words are unchanged, and q_overflow is set.
- R7: flag_we with flag_wdata clears q_underflow where bit 0 is 0 and q_overflow where bit 1 is 0, and keeps a flag where its bit is 1. A flag event in the same cycle wins over the clear.
- R8: q_empty is 1 exactly when no word is queued. q_full is 1 exactly when the queued count equals the ring size.
- R9: q_nearly_empty is 1 when the count is at most the nearly-empty level. Code 0 gives level 0, and code k>0 gives 2^(k−1) words.
- R10: q_nearly_full is 1 when the free space (size − count) is at most the nearly-full level, decoded the same way as in R9.
- R11: Size code 00/01/10/11 gives 16/32/64/128 words, and exactly that many pushes fill the queue.
- R12: A configuration write takes priority over a push or pop in the same cycle: those are ignored and pop_data keeps its value.
- R13: A simultaneous push and pop on a non-empty, non-full queue keeps the count unchanged. On a full queue the pop succeeds and the push is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write value |
| cfg_rdata | output | 32 | Configuration and pointer readback |
| push | input | 1 | Push strobe |
| push_data | input | DATA_W | Word to push |
| pop | input | 1 | Pop strobe |
| pop_data | output | DATA_W | Last popped word, zero after an empty pop |
| flag_we | input | 1 | Sticky flag write-back strobe |
| flag_wdata | input | 2 | Bit 0 keeps underflow, bit 1 keeps overflow |
| q_empty | output | 1 | Queue empty |
| q_nearly_empty | output | 1 | Count at or below nearly-empty level |
| q_nearly_full | output | 1 | Free space at or below nearly-full level |
| q_full | output | 1 | Queue full |
| q_underflow | output | 1 | Sticky underflow flag |
| q_overflow | output | 1 | Sticky overflow flag |

## Verification
Two conditions are the hardest to reach from the ports: the tail and head pointers wrapping past 127 while the ring itself wraps at a smaller size, and a push colliding with a pop while the queue is exactly full. For the first, the bench prefills a few words and then streams more than 128 simultaneous push/pop pairs, so both pointers cross the 7-bit boundary while words are still queued. For the second, it fills each ring size completely and only then issues a combined push and pop. All 64 watermark code pairs are swept on the smallest ring, with the thresholds computed arithmetically at every fill level.

// File: rtl/sqc_pkg.sv
package sqc_pkg;
  localparam int PTR_W  = 7;
  localparam int CNT_W  = 8;
  localparam int BASE_W = 7;
  localparam int LOC_W  = 12;

  // configuration word field positions
  localparam int RPTR_LSB = 7;
  localparam int SIZE_LSB = 16;
  localparam int BASE_LSB = 18;
  localparam int NE_LSB   = 25;
  localparam int NF_LSB   = 28;

  typedef struct packed {
    logic [2:0]        nf;
    logic [2:0]        ne;
    logic [BASE_W-1:0] base;
    logic [1:0]        size;
  } qcfg_t;

  function automatic logic [CNT_W-1:0] size_words(input logic [1:0] code);
    return CNT_W'(16) << code;
  endfunction

  function automatic logic [CNT_W-1:0] wm_level(input logic [2:0] code);
    if (code == 3'd0) return '0;
    return CNT_W'(1) << (code - 3'd1);
  endfunction

  function automatic logic [LOC_W-1:0] sram_loc(input logic [BASE_W-1:0] base,
                                                input logic [PTR_W-1:0]  ptr,
                                                input logic [1:0]        code);
    logic [PTR_W-1:0] mask;
    mask = PTR_W'(size_words(code) - CNT_W'(1));
    return LOC_W'({base, 4'b0000}) + LOC_W'(ptr & mask);
  endfunction

  function automatic qcfg_t cfg_from_word(input logic [31:0] w);
    qcfg_t c;
    c.size = w[SIZE_LSB +: 2];
    c.base = w[BASE_LSB +: BASE_W];
    c.ne   = w[NE_LSB +: 3];
    c.nf   = w[NF_LSB +: 3];
    return c;
  endfunction
endpackage

// File: rtl/sqc_ctrl.sv
module sqc_ctrl
  import sqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  qcfg_t            cfg_in,
  input  logic             push,
  input  logic             pop,
  output qcfg_t            cfg_q,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic [CNT_W-1:0] count,
  output logic             push_ok,
  output logic             push_drop,
  output logic             pop_ok,
  output logic             pop_miss
);
  logic [CNT_W-1:0] ring_words;
  logic             is_full, is_empty, active;

  assign ring_words = size_words(cfg_q.size);
  assign is_full    = (count == ring_words);
  assign is_empty   = (count == '0);
  assign active     = !cfg_we;

  assign push_ok   = active && push && !is_full;
  assign push_drop = active && push &&  is_full;
  assign pop_ok    = active && pop  && !is_empty;
  assign pop_miss  = active && pop  &&  is_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_in;
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr + PTR_W'(push_ok);
      rptr  <= rptr + PTR_W'(pop_ok);
      count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ring_words); // R11
  AST_CFG_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (count == '0 && wptr == '0 && rptr == '0)); // R2
  AST_PTR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    PTR_W'(wptr - rptr) == count[PTR_W-1:0]); // R4
  AST_DROP_KEEPS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> wptr == $past(wptr)); // R6
  AST_MISS_KEEPS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    pop_miss |=> rptr == $past(rptr)); // R5
endmodule

// File: rtl/sqc_flags.sv
module sqc_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pop_miss,
  input  logic       push_drop,
  input  logic       clr_we,
  input  logic [1:0] clr_keep,
  output logic       uflow,
  output logic       oflow
);
  logic drop_u, drop_o;

  assign drop_u = clr_we && !clr_keep[0];
  assign drop_o = clr_we && !clr_keep[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uflow <= 1'b0;
      oflow <= 1'b0;
    end else begin
      uflow <= (uflow && !drop_u) || pop_miss;
      oflow <= (oflow && !drop_o) || push_drop;
    end
  end

  AST_UFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pop_miss |=> uflow); // R5
  AST_OFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> oflow); // R6
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we && !pop_miss && !push_drop) |=> (uflow == $past(uflow) && oflow == $past(oflow))); // R7
endmodule

// File: rtl/sqc_status.sv
module sqc_status
  import sqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  qcfg_t            cfg,
  output logic             empty,
  output logic             nearly_empty,
  output logic             nearly_full,
  output logic             full
);
  logic [CNT_W-1:0] ring_words, free_words;

  assign ring_words   = size_words(cfg.size);
  assign free_words   = ring_words - count;
  assign empty        = (count == '0);
  assign full         = (free_words == '0);
  assign nearly_empty = (count <= wm_level(cfg.ne));
  assign nearly_full  = (free_words <= wm_level(cfg.nf));

  AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full)); // R8
  AST_EMPTY_IS_NEARLY: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> nearly_empty); // R9
endmodule

// File: rtl/sqc_store.sv
module sqc_store #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 256,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_miss,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (rd_miss) rd_data <= '0;
    else if (rd_en)   rd_data <= mem[rd_addr];
  end

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_miss |=> rd_data == '0); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !rd_miss) |=> $stable(rd_data)); // R12
endmodule

// File: rtl/sram_queue_ctrl.sv
module sram_queue_ctrl
  import sqc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int SRAM_WORDS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  input  logic              flag_we,
  input  logic [1:0]        flag_wdata,
  output logic              q_empty,
  output logic              q_nearly_empty,
  output logic              q_nearly_full,
  output logic              q_full,
  output logic              q_underflow,
  output logic              q_overflow
);
  localparam int AW = $clog2(SRAM_WORDS);

  qcfg_t            cfg_q;
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] count;
  logic             push_ok, push_drop, pop_ok, pop_miss;
  logic [LOC_W-1:0] wr_loc, rd_loc;
  logic             cfg_unused;

  assign cfg_unused = ^{cfg_wdata[31], cfg_wdata[15:0], wr_loc[LOC_W-1:AW], rd_loc[LOC_W-1:AW]};

  sqc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_in(cfg_from_word(cfg_wdata)),
    .push(push), .pop(pop), .cfg_q(cfg_q), .wptr(wptr), .rptr(rptr), .count(count),
    .push_ok(push_ok), .push_drop(push_drop), .pop_ok(pop_ok), .pop_miss(pop_miss)
  );

  assign wr_loc = sram_loc(cfg_q.base, wptr, cfg_q.size);
  assign rd_loc = sram_loc(cfg_q.base, rptr, cfg_q.size);

  sqc_store #(.DATA_W(DATA_W), .WORDS(SRAM_WORDS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(push_ok), .wr_addr(wr_loc[AW-1:0]), .wr_data(push_data),
    .rd_en(pop_ok), .rd_miss(pop_miss), .rd_addr(rd_loc[AW-1:0]), .rd_data(pop_data)
  );

  sqc_flags u_flags (
    .clk(clk), .rst_n(rst_n), .pop_miss(pop_miss), .push_drop(push_drop),
    .clr_we(flag_we), .clr_keep(flag_wdata), .uflow(q_underflow), .oflow(q_overflow)
  );

  sqc_status u_status (
    .clk(clk), .rst_n(rst_n), .count(count), .cfg(cfg_q),
    .empty(q_empty), .nearly_empty(q_nearly_empty),
    .nearly_full(q_nearly_full), .full(q_full)
  );

  assign cfg_rdata = {1'b0, cfg_q.nf, cfg_q.ne, cfg_q.base, cfg_q.size, 2'b00, rptr, wptr};

  AST_CFG_IGNORES_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (q_empty && $stable(pop_data))); // R12
endmodule

// File: tb/sram_queue_ctrl_tb_top.sv
module sram_queue_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, push, pop, flag_we;
  logic [31:0] cfg_wdata, push_data;
  logic [1:0]  flag_wdata;
  logic [31:0] cfg_rdata, pop_data;
  logic        q_empty, q_nearly_empty, q_nearly_full, q_full, q_underflow, q_overflow;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_queue_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .push(push), .push_data(push_data), .pop(pop), .pop_data(pop_data),
    .flag_we(flag_we), .flag_wdata(flag_wdata),
    .q_empty(q_empty), .q_nearly_empty(q_nearly_empty), .q_nearly_full(q_nearly_full),
    .q_full(q_full), .q_underflow(q_underflow), .q_overflow(q_overflow)
  );

  // reference model
  logic [1:0]  m_szc;
  logic [2:0]  m_nec, m_nfc;
  logic [6:0]  m_base;
  int          m_cnt, m_w, m_r;
  logic        m_uf, m_of;
  logic [31:0] m_pd;
  logic [31:0] m_mem [128];
  int          n_cmp = 0, n_bad = 0;

  function automatic int pow2(input int e);
    int v = 1;
    for (int k = 0; k < e; k++) v = v * 2;
    return v;
  endfunction
  function automatic int ring(input logic [1:0] c);
    return 16 * pow2(int'(c));
  endfunction
  function automatic int level(input logic [2:0] c);
    return (c == 3'd0) ? 0 : pow2(int'(c) - 1);
  endfunction
  function automatic logic [31:0] mkcfg(input logic [2:0] nf, input logic [2:0] ne,
                                        input logic [6:0] base, input logic [1:0] sz);
    return {1'b0, nf, ne, base, sz, 16'h0000};
  endfunction

  task automatic check_all(input string tag);
    logic [69:0] got, exp;
    int sz;
    sz  = ring(m_szc);
    got = {cfg_rdata, q_empty, q_nearly_empty, q_nearly_full, q_full, q_underflow, q_overflow, pop_data};
    exp = {1'b0, m_nfc, m_nec, m_base, m_szc, 2'b00, 7'(m_r), 7'(m_w),
           (m_cnt == 0), (m_cnt <= level(m_nec)), ((sz - m_cnt) <= level(m_nfc)),
           (m_cnt == sz), m_uf, m_of, m_pd};
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic p, input logic [31:0] pd, input logic q,
                       input logic fw, input logic [1:0] fd,
                       input logic cw, input logic [31:0] cd, input string tag);
    int sz;
    logic pok, wok, uset, oset;
    push = p; push_data = pd; pop = q; flag_we = fw; flag_wdata = fd;
    cfg_we = cw; cfg_wdata = cd;
    @(negedge clk);
    uset = 1'b0; oset = 1'b0;
    if (cw) begin
      m_szc = cd[17:16]; m_base = cd[24:18]; m_nec = cd[27:25]; m_nfc = cd[30:28];
      m_cnt = 0; m_w = 0; m_r = 0;
    end else begin
      sz  = ring(m_szc);
      pok = q && (m_cnt > 0);
      wok = p && (m_cnt < sz);
      uset = q && (m_cnt == 0);
      oset = p && (m_cnt == sz);
      if (uset) m_pd = 32'h0;
      if (pok) begin m_pd = m_mem[m_r % sz]; m_r = (m_r + 1) % 128; end
      if (wok) begin m_mem[m_w % sz] = pd; m_w = (m_w + 1) % 128; end
      m_cnt = m_cnt + int'(wok) - int'(pok);
    end
    if (fw) begin m_uf = m_uf & fd[0]; m_of = m_of & fd[1]; end
    m_uf = m_uf | uset;
    m_of = m_of | oset;
    push = 0; pop = 0; flag_we = 0; cfg_we = 0;
    check_all(tag);
  endtask

  task automatic do_push(input logic [31:0] d, input string tag);
    apply(1'b1, d, 1'b0, 1'b0, 2'b00, 1'b0, 32'h0, tag);
  endtask
  task automatic do_pop(input string tag);
    apply(1'b0, 32'h0, 1'b1, 1'b0, 2'b00, 1'b0, 32'h0, tag);
  endtask
  task automatic do_cfg(input logic [31:0] cd, input string tag);
    apply(1'b0, 32'h0, 1'b0, 1'b0, 2'b00, 1'b1, cd, tag);
  endtask
  task automatic do_flags(input logic [1:0] fd, input string tag);
    apply(1'b0, 32'h0, 1'b0, 1'b1, fd, 1'b0, 32'h0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int sz;
    rst_n = 1'b0; cfg_we = 0; push = 0; pop = 0; flag_we = 0;
    cfg_wdata = 0; push_data = 0; flag_wdata = 0;
    m_szc = 0; m_nec = 0; m_nfc = 0; m_base = 0;
    m_cnt = 0; m_w = 0; m_r = 0; m_uf = 0; m_of = 0; m_pd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // every ring size: fill, overflow, drain, underflow, streaming wrap, full collision
    for (int c = 0; c < 4; c++) begin
      sz = ring(2'(c));
      do_cfg(mkcfg(3'(c + 3), 3'(c + 2), 7'(2 * c), 2'(c)) | 32'h8000_ABCD, "R2");
      for (int i = 0; i < sz + 2; i++)
        do_push(32'h5A00_0000 ^ (c << 20) ^ (i * 32'h0001_0101) ^ 32'h1, "R6 R8 R11");
      for (int i = 0; i < sz + 1; i++)
        do_pop("R3 R5 R8");
      do_flags(2'b00, "R7");
      for (int i = 0; i < 5; i++) do_push(32'hC0DE_0000 + i, "R4");
      for (int i = 0; i < 140; i++)
        apply(1'b1, 32'h7700_0000 + i, 1'b1, 1'b0, 2'b00, 1'b0, 32'h0, "R3 R4 R13");
      for (int i = 0; i < 5; i++) do_pop("R3 R4");
      for (int i = 0; i < sz; i++) do_push(32'hF000_0000 | i, "R11");
      apply(1'b1, 32'hDEAD_BEEF, 1'b1, 1'b0, 2'b00, 1'b0, 32'h0, "R13");
      do_flags(2'b00, "R7");
    end

    // watermark sweep on the 16-word ring
    for (int ne = 0; ne < 8; ne++)
      for (int nf = 0; nf < 8; nf++) begin
        do_cfg(mkcfg(3'(nf), 3'(ne), 7'd1, 2'd0), "R2");
        for (int i = 0; i < 16; i++) do_push(32'h0100_0000 + i, "R9 R10");
      end

    // sticky flag write-back
    do_cfg(mkcfg(3'd1, 3'd1, 7'd0, 2'd0), "R2");
    do_pop("R5");
    for (int i = 0; i < 17; i++) do_push(32'h3300_0000 + i, "R6");
    do_flags(2'b11, "R7");
    do_flags(2'b10, "R7");
    for (int i = 0; i < 16; i++) do_pop("R3");
    apply(1'b0, 32'h0, 1'b1, 1'b1, 2'b00, 1'b0, 32'h0, "R7");
    do_flags(2'b01, "R7");
    do_flags(2'b00, "R7");

    // configuration write wins over traffic
    for (int i = 0; i < 3; i++) do_push(32'h4400_0000 + i, "R3");
    do_pop("R3");
    apply(1'b1, 32'h9999_9999, 1'b1, 1'b0, 2'b00, 1'b1, mkcfg(3'd2, 3'd2, 7'd4, 2'd1), "R12");
    do_pop("R12 R5");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule